// File: doc/BRIEF.md
# CPU Interrupt Mode Sequencer

This block owns the interrupt side of an 8-bit CPU core. It holds the two-bit interrupt mode register and the two interrupt enable flip-flops. It watches every completed instruction for the opcodes that change them, and at each instruction boundary it decides whether to take an interrupt. A non-maskable request is captured on its falling edge. A maskable request is a low level, sampled when the boundary is reported.

Once an interrupt is accepted, the block runs the acknowledge sequence and hands the core its new PC (and, where a push happened, its new SP) in a single completion pulse. The three maskable modes behave differently:

- Mode 0 forwards the byte the peripheral drives on the data bus as the next opcode.
- Mode 1 pushes the PC and jumps to a fixed address.
- Mode 2 pushes the PC and then fetches a 16-bit target from a table. The I register gives the high address byte and the data-bus byte gives the low address byte.

The non-maskable path pushes the PC and jumps to its own fixed address. It saves the enable state so that a return-from-NMI instruction can restore it.

The core reports a boundary by pulsing `instrDone`. On the same cycle it presents the completed opcode, its resume PC, its SP and whether it is halted. It must not report another boundary while `seqBusy` is high.

Top module: `intModeSeq`

## Requirements
- R1: After reset the mode is 0, `iff1` and `iff2` are 0, `pcOut` is 0x0000 and `seqBusy` is 0.
- R2: A two-byte opcode ED xx with xx of the form 01mm m110 sets the mode: bits [4:3] of 00 or 01 give mode 0, 10 gives mode 1, and 11 gives mode 2 (ED46, ED4E, ED66, ED6E → 0; ED56, ED76 → 1; ED5E, ED7E → 2). Any other ED opcode leaves the mode unchanged, and the mode never reads 3.
- R3: A maskable request (`irqN` low at a boundary) is ignored while `iff1` is 0. When it is accepted, both `iff1` and `iff2` are cleared before `intAck` is raised.
- R4: In mode 0, `intAck` is high for exactly one cycle, and the `dataBus` byte sampled in that cycle later appears on `injOpcode` with a one-cycle `injValid` that coincides with `pcLoad`. `pcOut` equals the resume PC. There is no memory access and no `spLoad`.
- R5: In mode 1, the PC high byte is written to SP-1 and then the low byte to SP-2. `pcLoad` then gives `pcOut` = 0x0038, and `spLoad` gives `spOut` = SP-2.
- R6: In mode 2, after the push, the byte at {I, bus byte} is read into the low half of the PC and the byte at that address + 1 into the high half.
- R7: A falling edge on `nmiN` is latched. At the next boundary it is taken regardless of `iff1`: `iff1` is copied into `iff2`, `iff1` is cleared, the PC is pushed and `pcOut` = 0x0066, with no `intAck`.
- R8: When a latched NMI and a maskable request meet at the same boundary, the NMI is taken.
- R9: When `halted` is high at the accepted boundary, the pushed or resumed PC is `pcIn` + 1.
- R10: EI (single byte FB) sets both flip-flops and DI (single byte F3) clears both. No interrupt of either kind is taken at the boundary that ends EI or DI.
- R11: A two-byte opcode ED 01xx x101 (return from interrupt) copies `iff2` into `iff1`. The current `iff2` is visible on its port.
- R12: `seqBusy` rises the cycle after an accepted boundary and falls the cycle after `pcLoad`. `memReq` is only ever high while `seqBusy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | One-cycle pulse: instruction boundary |
| opTwoByte | input | 1 | Completed opcode had a prefix byte |
| opFirst | input | 8 | First opcode byte (the only byte if single) |
| opSecond | input | 8 | Second opcode byte |
| halted | input | 1 | Core is sitting in HALT |
| pcIn | input | 16 | Resume PC at the boundary |
| spIn | input | 16 | Stack pointer at the boundary |
| irqN | input | 1 | Maskable request, active low, level |
| nmiN | input | 1 | Non-maskable request, falling-edge |
| iRegIn | input | 8 | I register |
| dataBus | input | 8 | Peripheral data-bus byte |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 16 | Request address |
| memWdata | output | 8 | Write data |
| memAck | input | 1 | Request accepted this cycle |
| memRdata | input | 8 | Read data, valid with memAck |
| seqBusy | output | 1 | Acknowledge sequence in progress |
| intAck | output | 1 | Maskable acknowledge cycle |
| pcLoad | output | 1 | Load pcOut into the PC |
| pcOut | output | 16 | New PC |
| spLoad | output | 1 | Load spOut into the SP |
| spOut | output | 16 | New SP |
| injValid | output | 1 | injOpcode is the next opcode |
| injOpcode | output | 8 | Opcode taken from the data bus |
| mode | output | 2 | Interrupt mode |
| iff1 | output | 1 | Enable flip-flop 1 |
| iff2 | output | 1 | Enable flip-flop 2 |

## Verification
A corrupted mode register or enable flip-flop is visible on `mode`, `iff1` and `iff2` one cycle after the boundary that wrote it. It also shows up at the next accepted request as the wrong acknowledge shape: memory traffic present or missing, or a wrong `pcOut`.

An error in the saved return PC, SP base or table address appears only at the end of the sequence, a few cycles later. It shows as wrong write addresses or data on the memory port, or as a wrong `pcOut` with `pcLoad`.

A stale NMI latch shows up at the following boundary as an unexpected jump to 0x0066.

// File: rtl/intModeSeqPkg.sv
package intModeSeqPkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_PUSH_HI, S_PUSH_LO, S_VEC_LO, S_VEC_HI, S_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    MEM_NONE, MEM_PUSH_HI, MEM_PUSH_LO, MEM_VEC_LO, MEM_VEC_HI
  } memSel_t;

  typedef struct packed {
    logic    captureCtx;
    logic    applyInstr;
    logic    nmiIffs;
    logic    irqIffs;
    logic    clrNmi;
    logic    latchBus;
    logic    loadFixed;
    logic    fixedIsNmi;
    logic    loadRet;
    logic    loadVecLo;
    logic    loadVecHi;
    memSel_t memSel;
  } strobes_t;

  typedef struct packed {
    logic       setMode;
    logic [1:0] modeVal;
    logic       isEi;
    logic       isDi;
    logic       isRetn;
  } decode_t;

  localparam logic [BYTE_W-1:0] OP_PREFIX = 8'hED;
  localparam logic [BYTE_W-1:0] OP_EI     = 8'hFB;
  localparam logic [BYTE_W-1:0] OP_DI     = 8'hF3;

  function automatic decode_t decodeOp(input logic twoByte,
                                       input logic [BYTE_W-1:0] first,
                                       input logic [BYTE_W-1:0] second);
    decode_t d;
    d = '0;
    if (twoByte) begin
      if (first == OP_PREFIX && second[7:6] == 2'b01) begin
        if (second[2:0] == 3'b110) begin
          d.setMode = 1'b1;
          if (!second[4])     d.modeVal = 2'd0;
          else if (!second[3]) d.modeVal = 2'd1;
          else                 d.modeVal = 2'd2;
        end
        if (second[2:0] == 3'b101) d.isRetn = 1'b1;
      end
    end else begin
      d.isEi = (first == OP_EI);
      d.isDi = (first == OP_DI);
    end
    return d;
  endfunction

endpackage

// File: rtl/intModeSeqData.sv
module intModeSeqData
  import intModeSeqPkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_NMI  = 16'h0066,
  parameter logic [WORD_W-1:0] VEC_IRQ1 = 16'h0038,
  parameter int                HALT_LEN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic              opTwoByte,
  input  logic [BYTE_W-1:0] opFirst,
  input  logic [BYTE_W-1:0] opSecond,
  input  logic              halted,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic              nmiN,
  input  logic [BYTE_W-1:0] iRegIn,
  input  logic [BYTE_W-1:0] dataBus,
  input  logic [BYTE_W-1:0] memRdata,
  output decode_t           dec,
  output logic              iff1After,
  output logic              nmiPend,
  output logic [1:0]        mode,
  output logic              iff1,
  output logic              iff2,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic [BYTE_W-1:0] injOpcode,
  output logic [WORD_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata
);

  localparam logic [WORD_W-1:0] HALT_STEP = WORD_W'(HALT_LEN);

  logic [1:0]        modeQ;
  logic              iff1Q, iff2Q;
  logic              nmiPrev, nmiPendQ;
  logic [WORD_W-1:0] retPc, spBase, tableAddr, target;
  logic [BYTE_W-1:0] busByte;

  assign dec = decodeOp(opTwoByte, opFirst, opSecond);

  always_comb begin
    if (dec.isEi)        iff1After = 1'b1;
    else if (dec.isDi)   iff1After = 1'b0;
    else if (dec.isRetn) iff1After = iff2Q;
    else                 iff1After = iff1Q;
  end

  // request edge capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b1;
      nmiPendQ <= 1'b0;
    end else begin
      nmiPrev <= nmiN;
      if (st.clrNmi)         nmiPendQ <= 1'b0;
      if (nmiPrev && !nmiN)  nmiPendQ <= 1'b1;
    end
  end

  // mode and enable state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 2'd0;
      iff1Q <= 1'b0;
      iff2Q <= 1'b0;
    end else begin
      if (st.applyInstr) begin
        if (dec.setMode) modeQ <= dec.modeVal;
        iff1Q <= iff1After;
        if (dec.isEi) iff2Q <= 1'b1;
        if (dec.isDi) iff2Q <= 1'b0;
      end
      if (st.nmiIffs) begin
        iff2Q <= iff1After;
        iff1Q <= 1'b0;
      end
      if (st.irqIffs) begin
        iff1Q <= 1'b0;
        iff2Q <= 1'b0;
      end
    end
  end

  // sequence context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      retPc     <= '0;
      spBase    <= '0;
      tableAddr <= '0;
      busByte   <= '0;
      target    <= '0;
    end else begin
      if (st.captureCtx) begin
        retPc  <= halted ? pcIn + HALT_STEP : pcIn;
        spBase <= spIn;
      end
      if (st.latchBus) begin
        busByte   <= dataBus;
        tableAddr <= {iRegIn, dataBus};
      end
      if (st.loadFixed) target <= st.fixedIsNmi ? VEC_NMI : VEC_IRQ1;
      if (st.loadRet)   target <= retPc;
      if (st.loadVecLo) target[BYTE_W-1:0]      <= memRdata;
      if (st.loadVecHi) target[WORD_W-1:BYTE_W] <= memRdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    unique case (st.memSel)
      MEM_PUSH_HI: begin
        memAddr  = spBase - WORD_W'(1);
        memWdata = retPc[WORD_W-1:BYTE_W];
      end
      MEM_PUSH_LO: begin
        memAddr  = spBase - WORD_W'(2);
        memWdata = retPc[BYTE_W-1:0];
      end
      MEM_VEC_LO: memAddr = tableAddr;
      MEM_VEC_HI: memAddr = tableAddr + WORD_W'(1);
      default: ;
    endcase
  end

  assign nmiPend   = nmiPendQ;
  assign mode      = modeQ;
  assign iff1      = iff1Q;
  assign iff2      = iff2Q;
  assign pcOut     = target;
  assign spOut     = spBase - WORD_W'(2);
  assign injOpcode = busByte;

endmodule

// File: rtl/intModeSeqCtrl.sv
module intModeSeqCtrl
  import intModeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  decode_t    dec,
  input  logic       iff1After,
  input  logic       nmiPend,
  input  logic       irqN,
  input  logic [1:0] mode,
  input  logic       memAck,
  output strobes_t   st,
  output logic       seqBusy,
  output logic       intAck,
  output logic       pcLoad,
  output logic       spLoad,
  output logic       injValid,
  output logic       memReq,
  output logic       memWe
);

  seqState_t state, stateNext;
  logic needVec, needVecNext;
  logic inject, injectNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      needVec <= 1'b0;
      inject  <= 1'b0;
    end else begin
      state   <= stateNext;
      needVec <= needVecNext;
      inject  <= injectNext;
    end
  end

  always_comb begin
    st          = '0;
    stateNext   = state;
    needVecNext = needVec;
    injectNext  = inject;
    intAck      = 1'b0;
    pcLoad      = 1'b0;
    spLoad      = 1'b0;
    injValid    = 1'b0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (instrDone) begin
          st.applyInstr = 1'b1;
          st.captureCtx = 1'b1;
          if (!(dec.isEi || dec.isDi)) begin
            if (nmiPend) begin
              st.nmiIffs    = 1'b1;
              st.clrNmi     = 1'b1;
              st.loadFixed  = 1'b1;
              st.fixedIsNmi = 1'b1;
              needVecNext   = 1'b0;
              injectNext    = 1'b0;
              stateNext     = S_PUSH_HI;
            end else if (!irqN && iff1After) begin
              st.irqIffs  = 1'b1;
              needVecNext = 1'b0;
              injectNext  = 1'b0;
              stateNext   = S_ACK;
            end
          end
        end
      end
      S_ACK: begin
        intAck      = 1'b1;
        st.latchBus = 1'b1;
        if (mode == 2'd0) begin
          st.loadRet = 1'b1;
          injectNext = 1'b1;
          stateNext  = S_DONE;
        end else if (mode == 2'd1) begin
          st.loadFixed = 1'b1;
          stateNext    = S_PUSH_HI;
        end else begin
          needVecNext = 1'b1;
          stateNext   = S_PUSH_HI;
        end
      end
      S_PUSH_HI: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.memSel = MEM_PUSH_HI;
        if (memAck) stateNext = S_PUSH_LO;
      end
      S_PUSH_LO: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.memSel = MEM_PUSH_LO;
        if (memAck) stateNext = needVec ? S_VEC_LO : S_DONE;
      end
      S_VEC_LO: begin
        memReq    = 1'b1;
        st.memSel = MEM_VEC_LO;
        if (memAck) begin
          st.loadVecLo = 1'b1;
          stateNext    = S_VEC_HI;
        end
      end
      S_VEC_HI: begin
        memReq    = 1'b1;
        st.memSel = MEM_VEC_HI;
        if (memAck) begin
          st.loadVecHi = 1'b1;
          stateNext    = S_DONE;
        end
      end
      S_DONE: begin
        pcLoad      = 1'b1;
        spLoad      = !inject;
        injValid    = inject;
        injectNext  = 1'b0;
        needVecNext = 1'b0;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign seqBusy = (state != S_IDLE);

endmodule

// File: rtl/intModeSeq.sv
module intModeSeq
  import intModeSeqPkg::*;
#(
  parameter logic [15:0] VEC_NMI  = 16'h0066,
  parameter logic [15:0] VEC_IRQ1 = 16'h0038,
  parameter int          HALT_LEN = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        opTwoByte,
  input  logic [7:0]  opFirst,
  input  logic [7:0]  opSecond,
  input  logic        halted,
  input  logic [15:0] pcIn,
  input  logic [15:0] spIn,
  input  logic        irqN,
  input  logic        nmiN,
  input  logic [7:0]  iRegIn,
  input  logic [7:0]  dataBus,
  output logic        memReq,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic        memAck,
  input  logic [7:0]  memRdata,
  output logic        seqBusy,
  output logic        intAck,
  output logic        pcLoad,
  output logic [15:0] pcOut,
  output logic        spLoad,
  output logic [15:0] spOut,
  output logic        injValid,
  output logic [7:0]  injOpcode,
  output logic [1:0]  mode,
  output logic        iff1,
  output logic        iff2
);

  strobes_t st;
  decode_t  dec;
  logic     iff1After;
  logic     nmiPend;

  intModeSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .dec(dec),
    .iff1After(iff1After), .nmiPend(nmiPend), .irqN(irqN), .mode(mode),
    .memAck(memAck), .st(st), .seqBusy(seqBusy), .intAck(intAck),
    .pcLoad(pcLoad), .spLoad(spLoad), .injValid(injValid),
    .memReq(memReq), .memWe(memWe)
  );

  intModeSeqData #(
    .VEC_NMI(VEC_NMI), .VEC_IRQ1(VEC_IRQ1), .HALT_LEN(HALT_LEN)
  ) i_data (
    .clk(clk), .rstN(rstN), .st(st), .opTwoByte(opTwoByte),
    .opFirst(opFirst), .opSecond(opSecond), .halted(halted),
    .pcIn(pcIn), .spIn(spIn), .nmiN(nmiN), .iRegIn(iRegIn),
    .dataBus(dataBus), .memRdata(memRdata), .dec(dec),
    .iff1After(iff1After), .nmiPend(nmiPend), .mode(mode),
    .iff1(iff1), .iff2(iff2), .pcOut(pcOut), .spOut(spOut),
    .injOpcode(injOpcode), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/intModeSeqChk.sv
module intModeSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       instrDone,
  input logic       opTwoByte,
  input logic [7:0] opFirst,
  input logic       seqBusy,
  input logic       intAck,
  input logic       pcLoad,
  input logic       memReq,
  input logic [1:0] mode,
  input logic       iff1,
  input logic       iff2
);

  // R2: mode register never holds the unused code
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd3);

  // R3: enables are already clear when the acknowledge cycle is shown
  a_r3_ack_clears_iff: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (!iff1 && !iff2));

  // R4: acknowledge lasts one cycle
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck);

  // R10: no sequence starts at an EI or DI boundary
  a_r10_no_take_after_eidi: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !seqBusy && !opTwoByte && (opFirst == 8'hFB || opFirst == 8'hF3))
      |=> !seqBusy);

  // R12: memory traffic only inside a sequence
  a_r12_mem_in_seq: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> seqBusy);

  // R12: completion pulse ends the sequence
  a_r12_load_ends: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !seqBusy);

endmodule

bind intModeSeq intModeSeqChk i_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .opTwoByte(opTwoByte),
  .opFirst(opFirst), .seqBusy(seqBusy), .intAck(intAck), .pcLoad(pcLoad),
  .memReq(memReq), .mode(mode), .iff1(iff1), .iff2(iff2)
);

// File: tb/test_intModeSeq.sv
module test_intModeSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrDone = 1'b0, opTwoByte = 1'b0, halted = 1'b0;
  logic [7:0]  opFirst = 8'h00, opSecond = 8'h00;
  logic [15:0] pcIn = 16'h0000, spIn = 16'h0000;
  logic        irqN = 1'b1, nmiN = 1'b1;
  logic [7:0]  iRegIn = 8'h00, dataBus = 8'h00;
  logic        memReq, memWe, memAck;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        seqBusy, intAck, pcLoad, spLoad, injValid;
  logic [15:0] pcOut, spOut;
  logic [7:0]  injOpcode;
  logic [1:0]  mode;
  logic        iff1, iff2;

  int tests = 0, fails = 0;

  // observation record
  int          nWr, nRd, nAck, nBusy;
  logic [15:0] wrAddr [2];
  logic [7:0]  wrData [2];
  logic        gotLoad, gotSpLoad, gotInj;
  logic [15:0] gotPc, gotSp;
  logic [7:0]  gotOp;

  always #5 clk = ~clk;

  intModeSeq i_intModeSeq (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign memAck   = memReq;
  assign memRdata = memByte(memAddr);

  always @(posedge clk) begin
    if (memReq && memAck && memWe) begin
      if (nWr < 2) begin
        wrAddr[nWr] <= memAddr;
        wrData[nWr] <= memWdata;
      end
      nWr <= nWr + 1;
    end
    if (memReq && memAck && !memWe) nRd <= nRd + 1;
  end

  always @(negedge clk) begin
    if (intAck) nAck++;
    if (seqBusy) nBusy++;
    if (intAck && i_intModeSeq.mode == 2'd0) ; // no-op guard
    if (pcLoad) begin
      gotLoad = 1'b1; gotPc = pcOut; gotSpLoad = spLoad; gotSp = spOut;
      gotInj = injValid; gotOp = injOpcode;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearObs();
    nWr = 0; nRd = 0; nAck = 0; nBusy = 0;
    gotLoad = 0; gotSpLoad = 0; gotInj = 0; gotPc = '0; gotSp = '0; gotOp = '0;
  endtask

  // one instruction boundary, then let any sequence run out
  task automatic boundary(input bit two, input logic [7:0] b0, input logic [7:0] b1,
                          input bit hlt, input logic [15:0] pc, input logic [15:0] sp);
    @(negedge clk);
    clearObs();
    opTwoByte = two; opFirst = b0; opSecond = b1; halted = hlt;
    pcIn = pc; spIn = sp; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0; opTwoByte = 1'b0; opFirst = 8'h00; halted = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic nmiEdge();
    @(negedge clk); nmiN = 1'b1;
    @(negedge clk); nmiN = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(mode == 2'd0, "R1 mode", mode, 0);
    check(!iff1 && !iff2, "R1 iff", {iff1, iff2}, 0);
    check(pcOut == 16'h0000, "R1 pcOut", pcOut, 0);
    check(!seqBusy, "R1 busy", seqBusy, 0);
  endtask

  task automatic testModeDecode();
    logic [7:0] codes [8] = '{8'h46, 8'h4E, 8'h56, 8'h5E, 8'h66, 8'h6E, 8'h76, 8'h7E};
    logic [1:0] exp   [8] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 2'd2};
    for (int k = 0; k < 8; k++) begin
      boundary(1'b1, 8'hED, codes[k], 1'b0, 16'h0100, 16'hF000);
      check(mode == exp[k], "R2 mode opcode", mode, exp[k]);
    end
    boundary(1'b1, 8'hED, 8'h47, 1'b0, 16'h0100, 16'hF000);
    check(mode == 2'd2, "R2 other ED no change", mode, 2);
    boundary(1'b0, 8'h56, 8'h00, 1'b0, 16'h0100, 16'hF000);
    check(mode == 2'd2, "R2 unprefixed no change", mode, 2);
  endtask

  task automatic testMasked();
    boundary(1'b0, 8'hF3, 8'h00, 1'b0, 16'h0100, 16'hF000);  // DI
    check(!iff1 && !iff2, "R10 DI clears", {iff1, iff2}, 0);
    irqN = 1'b0;
    boundary(1'b0, 8'h00, 8'h00, 1'b0, 16'h0100, 16'hF000);
    check(nBusy == 0 && nAck == 0 && !gotLoad, "R3 masked ignored", nBusy, 0);
    boundary(1'b0, 8'hFB, 8'h00, 1'b0, 16'h0100, 16'hF000);  // EI with request held
    check(iff1 && iff2, "R10 EI sets", {iff1, iff2}, 3);
    check(nBusy == 0 && !gotLoad, "R10 no take after EI", nBusy, 0);
    irqN = 1'b1;
  endtask

  task automatic testMode1(input bit hlt);
    logic [15:0] ret;
    ret = hlt ? 16'h2001 : 16'h1234;
    boundary(1'b1, 8'hED, 8'h56, 1'b0, 16'h0100, 16'hF000);
    boundary(1'b0, 8'hFB, 8'h00, 1'b0, 16'h0100, 16'hF000);
    irqN = 1'b0;
    boundary(1'b0, 8'h00, 8'h00, hlt, hlt ? 16'h2000 : 16'h1234, 16'hFF00);
    irqN = 1'b1;
    check(nAck == 1, "R3 one ack", nAck, 1);
    check(!iff1 && !iff2, "R3 accept clears iff", {iff1, iff2}, 0);
    check(nWr == 2 && wrAddr[0] == 16'hFEFF && wrData[0] == ret[15:8],
          hlt ? "R9 push hi" : "R5 push hi", {wrAddr[0], wrData[0]}, {16'hFEFF, ret[15:8]});
    check(wrAddr[1] == 16'hFEFE && wrData[1] == ret[7:0],
          hlt ? "R9 push lo" : "R5 push lo", {wrAddr[1], wrData[1]}, {16'hFEFE, ret[7:0]});
    check(gotLoad && gotPc == 16'h0038, "R5 vector", gotPc, 16'h0038);
    check(gotSpLoad && gotSp == 16'hFEFE, "R5 sp", gotSp, 16'hFEFE);
    check(!seqBusy, "R12 idle after", seqBusy, 0);
  endtask

  task automatic testMode2();
    logic [15:0] exp;
    exp = {memByte(16'h8011), memByte(16'h8010)};
    boundary(1'b1, 8'hED, 8'h7E, 1'b0, 16'h0100, 16'hF000);
    boundary(1'b0, 8'hFB, 8'h00, 1'b0, 16'h0100, 16'hF000);
    iRegIn = 8'h80; dataBus = 8'h10; irqN = 1'b0;
    boundary(1'b0, 8'h00, 8'h00, 1'b0, 16'h4567, 16'hC000);
    irqN = 1'b1; dataBus = 8'h00;
    check(nWr == 2 && wrData[0] == 8'h45 && wrData[1] == 8'h67, "R6 push", {wrData[0], wrData[1]}, 16'h4567);
    check(nRd == 2, "R6 two reads", nRd, 2);
    check(gotLoad && gotPc == exp, "R6 table vector", gotPc, exp);
  endtask

  task automatic testMode0();
    boundary(1'b1, 8'hED, 8'h66, 1'b0, 16'h0100, 16'hF000);
    boundary(1'b0, 8'hFB, 8'h00, 1'b0, 16'h0100, 16'hF000);
    dataBus = 8'hC7; irqN = 1'b0;
    boundary(1'b0, 8'h00, 8'h00, 1'b1, 16'h3000, 16'hC000);
    irqN = 1'b1; dataBus = 8'h00;
    check(nAck == 1, "R4 one ack", nAck, 1);
    check(gotInj && gotOp == 8'hC7, "R4 injected opcode", gotOp, 8'hC7);
    check(nWr == 0 && nRd == 0 && !gotSpLoad, "R4 no memory", nWr + nRd, 0);
    check(gotPc == 16'h3001, "R9 mode0 resume past halt", gotPc, 16'h3001);
  endtask

  task automatic testNmi();
    boundary(1'b0, 8'hFB, 8'h00, 1'b0, 16'h0100, 16'hF000);
    nmiEdge();
    irqN = 1'b0;  // also a maskable request: NMI must win
    boundary(1'b0, 8'h00, 8'h00, 1'b0, 16'h5A5A, 16'h8000);
    irqN = 1'b1;
    check(nAck == 0, "R8 NMI over IRQ", nAck, 0);
    check(gotLoad && gotPc == 16'h0066, "R7 NMI vector", gotPc, 16'h0066);
    check(!iff1 && iff2, "R7 iff save", {iff1, iff2}, 1);
    check(nWr == 2 && wrAddr[0] == 16'h7FFF && wrData[1] == 8'h5A, "R7 push", wrAddr[0], 16'h7FFF);
    boundary(1'b1, 8'hED, 8'h45, 1'b0, 16'h0100, 16'hF000);
    check(iff1 && iff2, "R11 restore", {iff1, iff2}, 3);
    // unmasked while iff1 clear
    boundary(1'b0, 8'hF3, 8'h00, 1'b0, 16'h0100, 16'hF000);
    nmiEdge();
    boundary(1'b0, 8'h00, 8'h00, 1'b0, 16'h0200, 16'h8000);
    check(gotLoad && gotPc == 16'h0066, "R7 NMI ignores iff1", gotPc, 16'h0066);
    check(!iff1 && !iff2, "R7 iff2 copies zero", {iff1, iff2}, 0);
    boundary(1'b0, 8'h00, 8'h00, 1'b0, 16'h0200, 16'h8000);
    check(!gotLoad, "R7 latch cleared", gotLoad, 0);
    nmiN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModeDecode();
    testMasked();
    testMode1(1'b0);
    testMode1(1'b1);
    testMode2();
    testMode0();
    testNmi();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule